// File: doc/BRIEF.md
# NAND Die Stage Sequencer

This block models the internal operation stages of one NAND flash die as seen from its multiplexed byte-wide host bus. The host marks each bus cycle with strobes: a command-latch strobe, an address-latch strobe, a write strobe that clocks a byte in, and a read strobe that clocks a byte out. The sequencer walks through address collection, page data moving into the register (TIR), register into the array (TIN), array into the register (TON), register out to the bus (TOR) and block erase (BER). It drives a ready line and a sticky fail flag. The durations of the array stages come from three timing inputs. These are sampled when a stage starts, and a value of zero counts as one cycle.

The sequencer covers plain page read, page program, block erase, cache program and internal copy. A second timer-free state machine is not used. Instead, one array timer is shared, so a cache program lets its TIN run in the background while the host already fills the next page. Any command, address or data cycle that does not fit the current state sets the fail flag and returns the die to idle. The fail flag is cleared only by the reset command. A status read returns a status byte at any time and does not disturb the sequence in progress.

States: IDLE, RD_ADDR (read or copy-source address), TON, TOR, PG_ADDR, TIR, TIN, XFER_WAIT (a program waits for the array), ER_ADDR, BER, CP_HOLD (copy source is loaded, waiting for the destination command) and CP_ADDR. Transitions: IDLE or TOR go to RD_ADDR on 00h, to PG_ADDR on 80h and to ER_ADDR on 60h. RD_ADDR goes to TON on 30h or 35h. TON goes to TOR, or to CP_HOLD when copying. TOR goes back to IDLE after the last byte. PG_ADDR goes to TIR on the first data byte. TIR goes to TIN on 10h, or to IDLE on 15h. A program that finds the array busy goes to XFER_WAIT instead. CP_HOLD goes to CP_ADDR on 85h. CP_ADDR goes to TIN on 10h. ER_ADDR goes to BER on D0h. TIN and BER go back to IDLE when the timer expires. An error from any state goes to IDLE, and so does the FFh command.

Top module: `nand_die_seq`

## Requirements
- R1: After reset the die reports ready high, fail low and stage 0 (idle). A status read then returns 60h.
- R2: Read: the sequence is 00h, five address cycles and 30h. This enters TON, and ready is low for exactly `t_read` cycles. The die then enters TOR, where each read strobe advances the output byte `io_out` = byte index 0, 1, … up to PAGE_BYTES-1. After the last byte the die returns to idle.
- R3: Program: the sequence is 80h, five address cycles, PAGE_BYTES data writes and 10h. This enters TIN, ready is low for exactly `t_prog` cycles, and the die then returns to idle.
- R4: Erase: the sequence is 60h, three address cycles and D0h. This enters BER from the address stage, and ready is low for exactly `t_erase` cycles.
- R5: Cache program: ending a filled page with 15h starts TIN in the background. Ready stays high and status bit 5 (array idle) reads 0. A later program confirm waits in stage 7 until the array is free and then runs its own TIN. Ready stays low through the wait and the second TIN.
- R6: Internal copy: the sequence is 00h, five address cycles and 35h. This runs TON for `t_read` cycles and then holds in stage 8 with ready high and no TOR. Next comes 85h, five address cycles and 10h, which runs TIN for `t_prog` cycles.
- R7: Command 70h selects the status byte on `io_out` until the next other command. Bit 6 is ready, bit 5 is array idle, bit 0 is fail and the other bits are 0. It is accepted in any state and does not alter the sequence or any busy time.
- R8: An unknown opcode, a command that is out of order for the current state, or a cycle with both latch strobes set latches fail and returns the die to idle. No array stage starts.
- R9: A confirm command after the wrong number of address cycles sets fail. So does an address cycle beyond the expected count (five, or three for erase).
- R10: A program confirm after fewer than PAGE_BYTES data writes sets fail. So does a data write beyond PAGE_BYTES.
- R11: Command FFh clears fail, aborts any array stage and returns the die to idle with ready high.
- R12: The stage output encodes 0 idle, 1 address, 2 TIR, 3 TIN, 4 TON, 5 TOR, 6 BER, 7 waiting for the array, 8 copy hold. Ready is low exactly in stages 3, 4, 6 and 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_in | input | 8 | Host bus byte in (command, address or data) |
| cmd_latch | input | 1 | Marks a write cycle as a command |
| addr_latch | input | 1 | Marks a write cycle as an address |
| wr_strobe | input | 1 | Clocks a byte in from the host |
| rd_strobe | input | 1 | Clocks a byte out to the host |
| t_read | input | TW | TON duration in cycles |
| t_prog | input | TW | TIN duration in cycles |
| t_erase | input | TW | BER duration in cycles |
| io_out | output | 8 | Status byte or TOR byte index |
| ready | output | 1 | High when the die accepts host cycles |
| fail | output | 1 | Sticky sequence-error flag |
| stage | output | 4 | Current stage code |

## Verification
The bench builds the block with PAGE_BYTES = 4 and TW = 8. It sets the timing inputs to 6, 30 and 12 cycles. The short page keeps every TIR and TOR byte count, and both count boundaries, within a few cycles. The long program time is longer than a whole page fill. This lets the cache-program test reach the case where a second confirm must wait for a background TIN, and the bench predicts that total wait from its own cycle count.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

    localparam logic [7:0] CMD_READ_SETUP  = 8'h00;
    localparam logic [7:0] CMD_READ_GO     = 8'h30;
    localparam logic [7:0] CMD_COPY_SRC    = 8'h35;
    localparam logic [7:0] CMD_PROG_SETUP  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO     = 8'h10;
    localparam logic [7:0] CMD_PROG_CACHE  = 8'h15;
    localparam logic [7:0] CMD_COPY_DST    = 8'h85;
    localparam logic [7:0] CMD_ERASE_SETUP = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO    = 8'hD0;
    localparam logic [7:0] CMD_STATUS      = 8'h70;
    localparam logic [7:0] CMD_RESET       = 8'hFF;

    localparam logic [2:0] PAGE_ADDR_CYCLES  = 3'd5;
    localparam logic [2:0] BLOCK_ADDR_CYCLES = 3'd3;

    typedef enum logic [3:0] {
        ST_IDLE, ST_RD_ADDR, ST_TON, ST_TOR, ST_PG_ADDR, ST_TIR, ST_TIN,
        ST_XFER_WAIT, ST_ER_ADDR, ST_BER, ST_CP_HOLD, ST_CP_ADDR
    } seq_state_e;

    typedef enum logic [3:0] {
        STG_IDLE = 4'd0, STG_ADDR = 4'd1, STG_TIR = 4'd2, STG_TIN = 4'd3,
        STG_TON = 4'd4, STG_TOR = 4'd5, STG_BER = 4'd6, STG_WAIT = 4'd7,
        STG_HOLD = 4'd8
    } stage_e;

    typedef enum logic [1:0] { DUR_READ, DUR_PROG, DUR_ERASE } dur_sel_e;

endpackage

// File: rtl/nand_bus_decode.sv
module nand_bus_decode (
    input  logic cmd_latch,
    input  logic addr_latch,
    input  logic wr_strobe,
    input  logic rd_strobe,
    output logic is_cmd,
    output logic is_addr,
    output logic is_data,
    output logic is_read,
    output logic is_bad
);
    always_comb begin
        is_cmd  = wr_strobe && cmd_latch && !addr_latch;
        is_addr = wr_strobe && addr_latch && !cmd_latch;
        is_data = wr_strobe && !cmd_latch && !addr_latch;
        is_read = rd_strobe && !wr_strobe;
        is_bad  = wr_strobe && cmd_latch && addr_latch;
    end
endmodule

// File: rtl/nand_stage_timer.sv
module nand_stage_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          abort,
    input  logic [TW-1:0] dur,
    output logic          busy,
    output logic          last
);
    logic [TW-1:0] count_q;

    always_ff @(posedge clk) begin
        if (!rst_n || abort)      count_q <= '0;
        else if (start)           count_q <= (dur == '0) ? TW'(1) : dur;
        else if (count_q != '0)   count_q <= count_q - TW'(1);
    end

    always_comb begin
        busy = (count_q != '0);
        last = (count_q == TW'(1));
    end
endmodule

// File: rtl/nand_seq_fsm.sv
module nand_seq_fsm
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] io_in,
    input  logic       is_cmd,
    input  logic       is_addr,
    input  logic       is_data,
    input  logic       is_read,
    input  logic       is_bad,
    input  logic       eng_busy,
    input  logic       eng_last,
    output logic       go,
    output dur_sel_e   go_sel,
    output logic       abort,
    output logic [7:0] io_out,
    output logic       ready,
    output logic       fail,
    output logic [3:0] stage
);
    localparam int BW = $clog2(PAGE_BYTES + 1);
    localparam logic [BW-1:0] PAGE_FULL = BW'(PAGE_BYTES);
    localparam logic [BW-1:0] PAGE_LAST = BW'(PAGE_BYTES - 1);

    seq_state_e    state_q, state_d;
    logic [2:0]    addr_q, addr_d;
    logic [BW-1:0] byte_q, byte_d;
    logic copy_q, copy_d, cache_q, cache_d, stat_q, stat_d, fail_q, fail_d;
    logic cmd_other, rd_bad, eng_free, err, want_prog, want_cache, do_rst;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE; addr_q <= '0; byte_q <= '0;
            copy_q  <= 1'b0; cache_q <= 1'b0; stat_q <= 1'b0; fail_q <= 1'b0;
        end else begin
            state_q <= state_d; addr_q <= addr_d; byte_q <= byte_d;
            copy_q  <= copy_d;  cache_q <= cache_d; stat_q <= stat_d; fail_q <= fail_d;
        end
    end

    always_comb begin
        state_d = state_q; addr_d = addr_q; byte_d = byte_q;
        copy_d = copy_q; cache_d = cache_q; stat_d = stat_q; fail_d = fail_q;
        go = 1'b0; go_sel = DUR_PROG; abort = 1'b0;
        err = is_bad; want_prog = 1'b0; want_cache = 1'b0;
        do_rst    = is_cmd && (io_in == CMD_RESET);
        cmd_other = is_cmd && (io_in != CMD_STATUS) && (io_in != CMD_RESET);
        rd_bad    = is_read && !stat_q;
        eng_free  = !eng_busy || eng_last;
        if (is_cmd && io_in == CMD_STATUS) stat_d = 1'b1;
        if (cmd_other) stat_d = 1'b0;

        unique case (state_q)
            ST_IDLE, ST_TOR: begin
                if (cmd_other) begin
                    addr_d = '0;
                    if (io_in == CMD_READ_SETUP && !eng_busy) begin
                        state_d = ST_RD_ADDR; copy_d = 1'b0;
                    end else if (io_in == CMD_PROG_SETUP) begin
                        state_d = ST_PG_ADDR; copy_d = 1'b0;
                    end else if (io_in == CMD_ERASE_SETUP && !eng_busy) begin
                        state_d = ST_ER_ADDR;
                    end else err = 1'b1;
                end else if (is_addr || is_data) err = 1'b1;
                else if (rd_bad) begin
                    if (state_q == ST_TOR) begin
                        byte_d = byte_q + BW'(1);
                        if (byte_q == PAGE_LAST) state_d = ST_IDLE;
                    end else err = 1'b1;
                end
            end
            ST_RD_ADDR, ST_PG_ADDR, ST_CP_ADDR, ST_ER_ADDR: begin
                if (is_addr) begin
                    if (addr_q == ((state_q == ST_ER_ADDR) ? BLOCK_ADDR_CYCLES : PAGE_ADDR_CYCLES))
                        err = 1'b1;
                    else addr_d = addr_q + 3'd1;
                end else if (is_data) begin
                    if (state_q == ST_PG_ADDR && addr_q == PAGE_ADDR_CYCLES) begin
                        state_d = ST_TIR; byte_d = BW'(1);
                    end else err = 1'b1;
                end else if (cmd_other) begin
                    if (state_q == ST_RD_ADDR && addr_q == PAGE_ADDR_CYCLES &&
                        (io_in == CMD_READ_GO || io_in == CMD_COPY_SRC)) begin
                        go = 1'b1; go_sel = DUR_READ; state_d = ST_TON;
                        copy_d = (io_in == CMD_COPY_SRC);
                    end else if (state_q == ST_CP_ADDR && addr_q == PAGE_ADDR_CYCLES &&
                                 io_in == CMD_PROG_GO) begin
                        want_prog = 1'b1;
                    end else if (state_q == ST_ER_ADDR && addr_q == BLOCK_ADDR_CYCLES &&
                                 io_in == CMD_ERASE_GO) begin
                        go = 1'b1; go_sel = DUR_ERASE; state_d = ST_BER;
                    end else err = 1'b1;
                end else if (rd_bad) err = 1'b1;
            end
            ST_TIR: begin
                if (is_data) begin
                    if (byte_q == PAGE_FULL) err = 1'b1;
                    else byte_d = byte_q + BW'(1);
                end else if (cmd_other) begin
                    if (byte_q == PAGE_FULL &&
                        (io_in == CMD_PROG_GO || io_in == CMD_PROG_CACHE)) begin
                        want_prog = 1'b1; want_cache = (io_in == CMD_PROG_CACHE);
                    end else err = 1'b1;
                end else if (is_addr || rd_bad) err = 1'b1;
            end
            ST_CP_HOLD: begin
                if (cmd_other && io_in == CMD_COPY_DST) begin
                    state_d = ST_CP_ADDR; addr_d = '0;
                end else if (cmd_other || is_addr || is_data || rd_bad) err = 1'b1;
            end
            ST_TON, ST_TIN, ST_BER, ST_XFER_WAIT: begin
                if (cmd_other || is_addr || is_data || rd_bad) err = 1'b1;
                else if (state_q == ST_XFER_WAIT) begin
                    if (eng_free) begin
                        want_prog = 1'b1; want_cache = cache_q;
                    end
                end else if (eng_last) begin
                    if (state_q != ST_TON) state_d = ST_IDLE;
                    else begin
                        state_d = copy_q ? ST_CP_HOLD : ST_TOR; byte_d = '0;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase

        if (want_prog) begin
            if (eng_free) begin
                go = 1'b1; go_sel = DUR_PROG; cache_d = 1'b0;
                state_d = want_cache ? ST_IDLE : ST_TIN;
            end else begin
                state_d = ST_XFER_WAIT; cache_d = want_cache;
            end
        end
        if (err) begin
            go = 1'b0; fail_d = 1'b1; state_d = ST_IDLE;
        end
        if (do_rst) begin
            state_d = ST_IDLE; addr_d = '0; byte_d = '0; copy_d = 1'b0;
            cache_d = 1'b0; stat_d = 1'b0; fail_d = 1'b0; abort = 1'b1; go = 1'b0;
        end
    end

    always_comb begin
        ready = !(state_q inside {ST_TON, ST_TIN, ST_BER, ST_XFER_WAIT});
        fail  = fail_q;
        unique case (state_q)
            ST_RD_ADDR, ST_PG_ADDR, ST_CP_ADDR, ST_ER_ADDR: stage = STG_ADDR;
            ST_TIR:       stage = STG_TIR;
            ST_TIN:       stage = STG_TIN;
            ST_TON:       stage = STG_TON;
            ST_TOR:       stage = STG_TOR;
            ST_BER:       stage = STG_BER;
            ST_XFER_WAIT: stage = STG_WAIT;
            ST_CP_HOLD:   stage = STG_HOLD;
            default:      stage = STG_IDLE;
        endcase
        if (stat_q)                io_out = {1'b0, ready, !eng_busy, 4'b0000, fail_q};
        else if (state_q == ST_TOR) io_out = 8'(byte_q);
        else                       io_out = 8'h00;
    end
endmodule

// File: rtl/nand_die_seq.sv
module nand_die_seq
    import nand_seq_pkg::*;
#(
    parameter int PAGE_BYTES = 8,
    parameter int TW         = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [7:0]    io_in,
    input  logic          cmd_latch,
    input  logic          addr_latch,
    input  logic          wr_strobe,
    input  logic          rd_strobe,
    input  logic [TW-1:0] t_read,
    input  logic [TW-1:0] t_prog,
    input  logic [TW-1:0] t_erase,
    output logic [7:0]    io_out,
    output logic          ready,
    output logic          fail,
    output logic [3:0]    stage
);
    logic is_cmd, is_addr, is_data, is_read, is_bad;
    logic go, abort, eng_busy, eng_last;
    dur_sel_e go_sel;
    logic [TW-1:0] go_dur;

    nand_bus_decode u_decode (
        .cmd_latch(cmd_latch), .addr_latch(addr_latch),
        .wr_strobe(wr_strobe), .rd_strobe(rd_strobe),
        .is_cmd(is_cmd), .is_addr(is_addr), .is_data(is_data),
        .is_read(is_read), .is_bad(is_bad)
    );

    always_comb begin
        unique case (go_sel)
            DUR_READ:  go_dur = t_read;
            DUR_ERASE: go_dur = t_erase;
            default:   go_dur = t_prog;
        endcase
    end

    nand_stage_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(go), .abort(abort),
        .dur(go_dur), .busy(eng_busy), .last(eng_last)
    );

    nand_seq_fsm #(.PAGE_BYTES(PAGE_BYTES)) u_fsm (
        .clk(clk), .rst_n(rst_n), .io_in(io_in),
        .is_cmd(is_cmd), .is_addr(is_addr), .is_data(is_data),
        .is_read(is_read), .is_bad(is_bad),
        .eng_busy(eng_busy), .eng_last(eng_last),
        .go(go), .go_sel(go_sel), .abort(abort),
        .io_out(io_out), .ready(ready), .fail(fail), .stage(stage)
    );
endmodule

// File: rtl/nand_die_seq_chk.sv
module nand_die_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] io_in,
    input logic       cmd_latch,
    input logic       addr_latch,
    input logic       wr_strobe,
    input logic       ready,
    input logic       fail,
    input logic [3:0] stage
);
    logic rst_cmd;
    assign rst_cmd = wr_strobe && cmd_latch && !addr_latch && (io_in == 8'hFF);

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_cmd |=> (!fail && ready && stage == 4'd0)); // R11
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !rst_cmd) |=> fail); // R8
    AST_BAD_STROBE_FAILS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_strobe && cmd_latch && addr_latch) |=> fail); // R8
    AST_TOR_AFTER_TON: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 4'd5 && $past(stage) != 4'd5) |-> ($past(stage) == 4'd4)); // R2
    AST_BER_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (stage == 4'd6 && $past(stage) != 4'd6) |-> ($past(stage) == 4'd1)); // R4
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (stage inside {4'd3, 4'd4, 4'd6, 4'd7}) |-> !ready); // R12
endmodule

bind nand_die_seq nand_die_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .io_in(io_in), .cmd_latch(cmd_latch),
    .addr_latch(addr_latch), .wr_strobe(wr_strobe), .ready(ready),
    .fail(fail), .stage(stage)
);

// File: tb/nand_die_seq_bench.sv
module nand_die_seq_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PB = 4;
    localparam int TWB = 8;
    localparam int TR = 6, TP = 30, TE = 12;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [7:0] din = 8'h00;
    logic cle = 1'b0, ale = 1'b0, we = 1'b0, re = 1'b0;
    logic [7:0] dout;
    logic rdy, flt;
    logic [3:0] stg;
    int checks = 0, failures = 0, cyc_no = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc_no <= cyc_no + 1;

    nand_die_seq #(.PAGE_BYTES(PB), .TW(TWB)) u_nand_die_seq (
        .clk(clk), .rst_n(rst_n), .io_in(din), .cmd_latch(cle),
        .addr_latch(ale), .wr_strobe(we), .rd_strobe(re),
        .t_read(TWB'(TR)), .t_prog(TWB'(TP)), .t_erase(TWB'(TE)),
        .io_out(dout), .ready(rdy), .fail(flt), .stage(stg)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input logic c, input logic a, input logic w, input logic r, input logic [7:0] d);
        din = d; cle = c; ale = a; we = w; re = r;
        @(negedge clk);
        din = 8'h00; cle = 1'b0; ale = 1'b0; we = 1'b0; re = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] op);   cyc(1, 0, 1, 0, op);   endtask
    task automatic addrs(input int n);
        for (int i = 0; i < n; i++) cyc(0, 1, 1, 0, 8'(i));
    endtask
    task automatic datas(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 1, 0, 8'(8'hA0 + i));
    endtask

    task automatic wait_busy(output int n);
        n = 0;
        while (!rdy && n < 5000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic t_reset_state();
        chk(rdy == 1'b1, "R1 ready", int'(rdy), 1);
        chk(flt == 1'b0, "R1 fail", int'(flt), 0);
        chk(stg == 4'd0, "R1 stage", int'(stg), 0);
        cmd(8'h70);
        chk(dout == 8'h60, "R1 status", int'(dout), 8'h60);
        cmd(8'hFF);
    endtask

    task automatic t_read();
        int n;
        cmd(8'hFF);
        cmd(8'h00);
        chk(stg == 4'd1, "R12 addr stage", int'(stg), 1);
        addrs(5);
        cmd(8'h30);
        chk(stg == 4'd4, "R2 TON stage", int'(stg), 4);
        wait_busy(n);
        chk(n == TR, "R2 TON busy", n, TR);
        chk(stg == 4'd5, "R2 TOR stage", int'(stg), 5);
        for (int i = 0; i < PB; i++) begin
            chk(dout == 8'(i), "R2 TOR byte", int'(dout), i);
            cyc(0, 0, 0, 1, 8'h00);
        end
        chk(stg == 4'd0, "R2 idle after TOR", int'(stg), 0);
        chk(flt == 1'b0, "R2 no fail", int'(flt), 0);
    endtask

    task automatic t_program();
        int n;
        cmd(8'hFF);
        cmd(8'h80); addrs(5); datas(1);
        chk(stg == 4'd2, "R3 TIR stage", int'(stg), 2);
        datas(PB - 1);
        cmd(8'h10);
        chk(stg == 4'd3, "R3 TIN stage", int'(stg), 3);
        wait_busy(n);
        chk(n == TP, "R3 TIN busy", n, TP);
        chk(stg == 4'd0 && !flt, "R3 idle ok", int'(stg), 0);
    endtask

    task automatic t_erase();
        int n;
        cmd(8'hFF);
        cmd(8'h60); addrs(3); cmd(8'hD0);
        chk(stg == 4'd6, "R4 BER stage", int'(stg), 6);
        wait_busy(n);
        chk(n == TE, "R4 BER busy", n, TE);
        chk(!flt, "R4 no fail", int'(flt), 0);
    endtask

    task automatic t_cache();
        int n, c15, c10;
        cmd(8'hFF);
        cmd(8'h80); addrs(5); datas(PB); cmd(8'h15);
        c15 = cyc_no;
        chk(rdy == 1'b1, "R5 ready after cache", int'(rdy), 1);
        cmd(8'h70);
        chk(dout == 8'h40, "R5 status array busy", int'(dout), 8'h40);
        cmd(8'h80); addrs(5); datas(PB); cmd(8'h10);
        c10 = cyc_no;
        chk(stg == 4'd7, "R5 wait stage", int'(stg), 7);
        wait_busy(n);
        chk(n == 2 * TP - (c10 - c15), "R5 total busy", n, 2 * TP - (c10 - c15));
        chk(!flt && stg == 4'd0, "R5 idle ok", int'(flt), 0);
    endtask

    task automatic t_copy();
        int n;
        cmd(8'hFF);
        cmd(8'h00); addrs(5); cmd(8'h35);
        chk(stg == 4'd4, "R6 TON stage", int'(stg), 4);
        wait_busy(n);
        chk(n == TR, "R6 TON busy", n, TR);
        chk(stg == 4'd8 && rdy, "R6 hold no TOR", int'(stg), 8);
        cmd(8'h85); addrs(5); cmd(8'h10);
        chk(stg == 4'd3, "R6 TIN stage", int'(stg), 3);
        wait_busy(n);
        chk(n == TP, "R6 TIN busy", n, TP);
        chk(!flt, "R6 no fail", int'(flt), 0);
    endtask

    task automatic t_status_busy();
        int n;
        cmd(8'hFF);
        cmd(8'h00); addrs(5); cmd(8'h30);
        cmd(8'h70);
        chk(dout == 8'h00, "R7 status during TON", int'(dout), 0);
        wait_busy(n);
        chk(n + 1 == TR, "R7 busy undisturbed", n + 1, TR);
        chk(stg == 4'd5, "R7 sequence kept", int'(stg), 5);
    endtask

    task automatic t_illegal();
        cmd(8'hFF);
        cmd(8'hAB);
        chk(flt == 1'b1, "R8 unknown opcode", int'(flt), 1);
        cmd(8'h70);
        chk(dout == 8'h61, "R8 status fail bit", int'(dout), 8'h61);
        cmd(8'hFF);
        chk(!flt && rdy, "R11 reset clears", int'(flt), 0);
        cmd(8'h70);
        chk(dout == 8'h60, "R11 status after reset", int'(dout), 8'h60);
        cmd(8'h10);
        chk(flt && rdy, "R8 out of order confirm", int'(flt), 1);
        cmd(8'hFF);
        cyc(1, 1, 1, 0, 8'h00);
        chk(flt == 1'b1, "R8 both strobes", int'(flt), 1);
        cmd(8'h00); addrs(2); cmd(8'hFF);
        chk(stg == 4'd0 && !flt, "R11 abort address", int'(stg), 0);
    endtask

    task automatic t_counts();
        cmd(8'hFF);
        cmd(8'h00); addrs(4); cmd(8'h30);
        chk(flt && rdy, "R9 short address", int'(flt), 1);
        cmd(8'hFF);
        cmd(8'h60); addrs(4);
        chk(flt == 1'b1, "R9 extra erase address", int'(flt), 1);
        cmd(8'hFF);
        cmd(8'h80); addrs(5); datas(PB - 1); cmd(8'h10);
        chk(flt && rdy, "R10 short page", int'(flt), 1);
        cmd(8'hFF);
        cmd(8'h80); addrs(5); datas(PB + 1);
        chk(flt == 1'b1, "R10 extra byte", int'(flt), 1);
        cmd(8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_read();
        t_program();
        t_erase();
        t_cache();
        t_copy();
        t_status_busy();
        t_illegal();
        t_counts();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule